// File: doc/BRIEF.md
# Paired GPIO Port Controller

This block is a register-mapped controller for sixteen general-purpose pins, grouped as two 8-bit ports, port A and port B. Software reaches it through a simple register bus. Each access names a register index and carries two byte enables. A single byte enable reaches one port. Both enables together reach the pair as a 16-bit word, with port A in bits 7:0 and port B in bits 15:8.

Every pin has its own settings: direction, output level, pull enable, pull polarity, interrupt enable, interrupt edge polarity and a sticky interrupt flag. These settings can be combined freely. After reset the pad controls are all inactive, so every pin is high-impedance with no pull. A global lock bit keeps them that way until software clears it. This lets software program the full configuration before any pin starts to drive.

Pad inputs pass through a two-stage synchroniser before they are read or edge-detected. The block raises one combined interrupt line.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset, `pad_oe_o`, `pad_out_o`, `pad_pull_en_o`, `pad_pull_up_o`, `irq_o` and `bus_rdata_o` are all zero. A read of the lock register (index 8) returns 1 in bit 0.
- R2: While the lock bit is 1, register writes are stored and can be read back, but all four pad control outputs stay zero.
- R3: Writing the lock register with `bus_be_i[0]`=1 and `bus_wdata_i[0]`=0 clears the lock. Writing 1 never sets it again; only reset does. Once the lock is clear, `pad_oe_o` equals the direction register (1 = output) and `pad_out_o` equals the output register, from the clock edge that performs the write.
- R4: `bus_be_i[0]` enables bits 7:0 (port A) and `bus_be_i[1]` enables bits 15:8 (port B). A byte that is not enabled keeps its value.
- R5: The register indices are: 0 input (read-only), 1 output, 2 direction, 3 pull enable, 4 pull polarity (1 = up), 5 interrupt enable, 6 edge select (0 = rising, 1 = falling), 7 flags, 8 lock. Reads of any other index return 0, and writes to them are ignored.
- R6: A read, which is `bus_sel_i`=1 with `bus_we_i`=0, places the word on `bus_rdata_o` one clock after the access. The output holds that word until the next read. The input register returns the pad level sampled two clock edges earlier.
- R7: While unlocked, a pin's flag sets on the selected edge of its synchronised input. The flag becomes visible after the third rising clock edge following the pad change. No flag sets while the lock bit is 1.
- R8: Writing the flag register clears each enabled bit written 0 and keeps each bit written 1. An edge event in the same cycle as a clear wins, and the flag ends up set.
- R9: `irq_o` is the OR over all pins of the flag AND the interrupt enable. It follows the registers in the same cycle.
- R10: Changing a pin's edge-select bit while its input is steady never sets its flag.
- R11: For each pin, the pull is applied only when the pin is an input: `pad_pull_en_o` = pull enable AND NOT direction, and `pad_pull_up_o` = that value AND pull polarity. Both are zero while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register index |
| bus_be_i | input | 2 | Byte enables (bit 0 = port A, bit 1 = port B) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered |
| pad_in_i | input | 16 | Asynchronous pad input levels |
| pad_oe_o | output | 16 | Pad output enable |
| pad_out_o | output | 16 | Pad output level |
| pad_pull_en_o | output | 16 | Pad pull resistor enable |
| pad_pull_up_o | output | 16 | Pad pull polarity (1 = up) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The results of this block arrive at different times after a stimulus:

- Register writes reach the pad controls and `irq_o` right after the writing edge.
- Read data appears one edge after the access.
- The input register reflects a pad change two edges later.
- A flag from a pad edge appears three edges later.

The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge with these delays. It compares every output on the following falling edge. Directed checks wait the matching number of edges before they sample. The set-versus-clear race is placed by counting those same three edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPORT     = 2;
  localparam int REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_IN   = 4'd0,
    RG_OUT  = 4'd1,
    RG_DIR  = 4'd2,
    RG_PEN  = 4'd3,
    RG_PSEL = 4'd4,
    RG_IE   = 4'd5,
    RG_IES  = 4'd6,
    RG_IFG  = 4'd7,
    RG_LOCK = 4'd8
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] prev_q;

  assign stg_d[0] = d_i;
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    assign stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '{default: '0};
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[LAST];
    end
  end

  assign cur_o  = stg_q[LAST];
  assign prev_o = prev_q;
  assign rise_o = stg_q[LAST] & ~prev_q;
  assign fall_o = ~stg_q[LAST] & prev_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [W-1:0]         rise_i,
  input  logic [W-1:0]         fall_i,
  input  logic                 arm_i,
  output logic [W-1:0]         out_o,
  output logic [W-1:0]         dir_o,
  output logic [W-1:0]         pen_o,
  output logic [W-1:0]         psel_o,
  output logic [W-1:0]         ie_o,
  output logic [W-1:0]         ies_o,
  output logic [W-1:0]         ifg_o
);
  logic [W-1:0] out_q,  out_d;
  logic [W-1:0] dir_q,  dir_d;
  logic [W-1:0] pen_q,  pen_d;
  logic [W-1:0] psel_q, psel_d;
  logic [W-1:0] ie_q,   ie_d;
  logic [W-1:0] ies_q,  ies_d;
  logic [W-1:0] ifg_q,  ifg_d;
  logic [W-1:0] evt;

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    pen_d  = pen_q;
    psel_d = psel_q;
    ie_d   = ie_q;
    ies_d  = ies_q;
    ifg_d  = ifg_q;
    evt    = arm_i ? ((rise_i & ~ies_q) | (fall_i & ies_q)) : '0;
    if (wr_i) begin
      case (idx_i)
        RG_OUT:  out_d  = wdata_i;
        RG_DIR:  dir_d  = wdata_i;
        RG_PEN:  pen_d  = wdata_i;
        RG_PSEL: psel_d = wdata_i;
        RG_IE:   ie_d   = wdata_i;
        RG_IES:  ies_d  = wdata_i;
        RG_IFG:  ifg_d  = ifg_q & wdata_i;
        default: ;
      endcase
    end
    ifg_d = ifg_d | evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      pen_q  <= '0;
      psel_q <= '0;
      ie_q   <= '0;
      ies_q  <= '0;
      ifg_q  <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      pen_q  <= pen_d;
      psel_q <= psel_d;
      ie_q   <= ie_d;
      ies_q  <= ies_d;
      ifg_q  <= ifg_d;
    end
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign pen_o  = pen_q;
  assign psel_o = psel_q;
  assign ie_o   = ie_q;
  assign ies_o  = ies_q;
  assign ifg_o  = ifg_q;
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_sel_i,
  input  logic                       bus_we_i,
  input  logic [REG_IDX_W-1:0]       bus_addr_i,
  input  logic [NPORT-1:0]           bus_be_i,
  input  logic [NPORT*PORT_W-1:0]    bus_wdata_i,
  output logic [NPORT*PORT_W-1:0]    bus_rdata_o,
  input  logic [NPORT*PORT_W-1:0]    pad_in_i,
  output logic [NPORT*PORT_W-1:0]    pad_oe_o,
  output logic [NPORT*PORT_W-1:0]    pad_out_o,
  output logic [NPORT*PORT_W-1:0]    pad_pull_en_o,
  output logic [NPORT*PORT_W-1:0]    pad_pull_up_o,
  output logic                       irq_o
);
  localparam int DW = NPORT * PORT_W;

  logic          rst_n_int;
  logic [DW-1:0] smp_cur, smp_prev, smp_rise, smp_fall;
  logic [DW-1:0] out_all, dir_all, pen_all, psel_all, ie_all, ies_all, ifg_all;
  logic          lock_q, lock_d;
  logic [DW-1:0] rd_mux, rdata_q, rdata_d;
  logic          wr_acc, rd_acc, lock_clr;

  gpio_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  gpio_in_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_insync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (pad_in_i),
    .cur_o  (smp_cur),
    .prev_o (smp_prev),
    .rise_o (smp_rise),
    .fall_o (smp_fall)
  );

  assign wr_acc = bus_sel_i & bus_we_i;
  assign rd_acc = bus_sel_i & ~bus_we_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_port_bank #(.W(PORT_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .wr_i    (wr_acc & bus_be_i[p]),
      .idx_i   (bus_addr_i),
      .wdata_i (bus_wdata_i[p*PORT_W +: PORT_W]),
      .rise_i  (smp_rise[p*PORT_W +: PORT_W]),
      .fall_i  (smp_fall[p*PORT_W +: PORT_W]),
      .arm_i   (~lock_q),
      .out_o   (out_all[p*PORT_W +: PORT_W]),
      .dir_o   (dir_all[p*PORT_W +: PORT_W]),
      .pen_o   (pen_all[p*PORT_W +: PORT_W]),
      .psel_o  (psel_all[p*PORT_W +: PORT_W]),
      .ie_o    (ie_all[p*PORT_W +: PORT_W]),
      .ies_o   (ies_all[p*PORT_W +: PORT_W]),
      .ifg_o   (ifg_all[p*PORT_W +: PORT_W])
    );
  end

  // Lock: set by reset, cleared only by writing 0 to bit 0
  assign lock_clr = wr_acc & bus_be_i[0] & (bus_addr_i == RG_LOCK) & ~bus_wdata_i[0];
  assign lock_d   = lock_q & ~lock_clr;

  always_comb begin
    case (bus_addr_i)
      RG_IN:   rd_mux = smp_cur;
      RG_OUT:  rd_mux = out_all;
      RG_DIR:  rd_mux = dir_all;
      RG_PEN:  rd_mux = pen_all;
      RG_PSEL: rd_mux = psel_all;
      RG_IE:   rd_mux = ie_all;
      RG_IES:  rd_mux = ies_all;
      RG_IFG:  rd_mux = ifg_all;
      RG_LOCK: rd_mux = {{(DW-1){1'b0}}, lock_q};
      default: rd_mux = '0;
    endcase
    rdata_d = rd_acc ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      lock_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      lock_q  <= lock_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o   = rdata_q;
  assign pad_oe_o      = lock_q ? '0 : dir_all;
  assign pad_out_o     = lock_q ? '0 : out_all;
  assign pad_pull_en_o = lock_q ? '0 : (pen_all & ~dir_all);
  assign pad_pull_up_o = lock_q ? '0 : (pen_all & ~dir_all & psel_all);
  assign irq_o         = |(ifg_all & ie_all);
endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          lock,
  input logic [DW-1:0] ifg,
  input logic [DW-1:0] smp_cur,
  input logic [DW-1:0] smp_prev,
  input logic [DW-1:0] pad_oe,
  input logic [DW-1:0] pad_out,
  input logic [DW-1:0] pad_pull_en,
  input logic [DW-1:0] pad_pull_up,
  input logic          irq
);
  // R2
  locked_pads_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock |-> (pad_oe == '0 && pad_out == '0 && pad_pull_en == '0 && pad_pull_up == '0));

  // R3
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !lock |=> !lock);

  // R7
  no_flag_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock |=> ((ifg & ~$past(ifg)) == '0));

  // R10
  no_flag_without_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (smp_cur == smp_prev) |=> ((ifg & ~$past(ifg)) == '0));

  // R11
  pull_input_only_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pad_oe & pad_pull_en) == '0);

  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> (ifg != '0));
endmodule

bind gpio_pair_ctrl gpio_pair_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_int),
  .lock        (lock_q),
  .ifg         (ifg_all),
  .smp_cur     (smp_cur),
  .smp_prev    (smp_prev),
  .pad_oe      (pad_oe_o),
  .pad_out     (pad_out_o),
  .pad_pull_en (pad_pull_en_o),
  .pad_pull_up (pad_pull_up_o),
  .irq         (irq_o)
);

// File: tb/test_gpio_pair_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pair_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bus_sel_i, bus_we_i;
  logic [3:0]  bus_addr_i;
  logic [1:0]  bus_be_i;
  logic [15:0] bus_wdata_i, bus_rdata_o, pad_in_i;
  logic [15:0] pad_oe_o, pad_out_o, pad_pull_en_o, pad_pull_up_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  gpio_pair_ctrl i_gpio_pair_ctrl (.*);

  int checks = 0;
  int failures = 0;
  bit model_on = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_out, m_dir, m_pen, m_psel, m_ie, m_ies, m_ifg, m_rdata;
  logic [15:0] m_s1, m_cur, m_prev;
  logic        m_lock;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_cur;
      4'd1: return m_out;
      4'd2: return m_dir;
      4'd3: return m_pen;
      4'd4: return m_psel;
      4'd5: return m_ie;
      4'd6: return m_ies;
      4'd7: return m_ifg;
      4'd8: return {15'd0, m_lock};
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    {m_out, m_dir, m_pen, m_psel, m_ie, m_ies, m_ifg, m_rdata} = '0;
    {m_s1, m_cur, m_prev} = '0;
    m_lock = 1'b1;
  end

  always @(posedge clk_i) begin
    if (model_on) begin
      logic [15:0] mask, set, nifg;
      logic        wr;
      set  = m_lock ? 16'h0 : (((m_cur & ~m_prev) & ~m_ies) | ((~m_cur & m_prev) & m_ies));
      wr   = bus_sel_i & bus_we_i;
      mask = {{8{bus_be_i[1]}}, {8{bus_be_i[0]}}};
      if (bus_sel_i && !bus_we_i) m_rdata = m_read(bus_addr_i);
      nifg = m_ifg;
      if (wr) begin
        case (bus_addr_i)
          4'd1: m_out  = (m_out  & ~mask) | (bus_wdata_i & mask);
          4'd2: m_dir  = (m_dir  & ~mask) | (bus_wdata_i & mask);
          4'd3: m_pen  = (m_pen  & ~mask) | (bus_wdata_i & mask);
          4'd4: m_psel = (m_psel & ~mask) | (bus_wdata_i & mask);
          4'd5: m_ie   = (m_ie   & ~mask) | (bus_wdata_i & mask);
          4'd6: m_ies  = (m_ies  & ~mask) | (bus_wdata_i & mask);
          4'd7: nifg   = m_ifg & (bus_wdata_i | ~mask);
          4'd8: if (bus_be_i[0] && !bus_wdata_i[0]) m_lock = 1'b0;
          default: ;
        endcase
      end
      m_ifg  = nifg | set;
      m_prev = m_cur;
      m_cur  = m_s1;
      m_s1   = pad_in_i;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    if (model_on && !done) begin
      check("R3 pad_oe",      pad_oe_o,      m_lock ? 16'h0 : m_dir);
      check("R3 pad_out",     pad_out_o,     m_lock ? 16'h0 : m_out);
      check("R11 pull_en",    pad_pull_en_o, m_lock ? 16'h0 : (m_pen & ~m_dir));
      check("R11 pull_up",    pad_pull_up_o, m_lock ? 16'h0 : (m_pen & ~m_dir & m_psel));
      check("R9 irq",         {15'd0, irq_o}, {15'd0, |(m_ifg & m_ie)});
      check("R6 rdata",       bus_rdata_o,   m_rdata);
    end
  end

  task automatic bus_wr(logic [3:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_be_i = be; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(logic [3:0] a);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a; bus_be_i = 2'b11;
    @(negedge clk_i);
    bus_sel_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; bus_sel_i = 0; bus_we_i = 0; bus_addr_i = 0; bus_be_i = 0;
    bus_wdata_i = 0; pad_in_i = 0;
    idle(3);
    rst_ni = 1;
    idle(4);
    model_on = 1;

    // R1 reset state
    check("R1 pad_oe reset", pad_oe_o, 16'h0);
    check("R1 pull_en reset", pad_pull_en_o, 16'h0);
    check("R1 irq reset", {15'd0, irq_o}, 16'h0);
    bus_rd(4'd8);
    check("R1 lock reads 1", bus_rdata_o, 16'h0001);

    // R2 writes stored while locked
    bus_wr(4'd2, 2'b11, 16'hF00F);
    bus_wr(4'd1, 2'b11, 16'hA5A5);
    bus_wr(4'd3, 2'b11, 16'h0FF0);
    bus_wr(4'd4, 2'b11, 16'h00F0);
    check("R2 pads held while locked", pad_oe_o | pad_out_o | pad_pull_en_o, 16'h0);
    bus_rd(4'd2);
    check("R2 dir stored", bus_rdata_o, 16'hF00F);
    bus_rd(4'd4);
    check("R5 pull polarity index", bus_rdata_o, 16'h00F0);

    // R4 byte lanes
    bus_wr(4'd1, 2'b01, 16'h1234);
    bus_rd(4'd1);
    check("R4 low byte write", bus_rdata_o, 16'hA534);
    bus_wr(4'd1, 2'b10, 16'h5678);
    bus_rd(4'd1);
    check("R4 high byte write", bus_rdata_o, 16'h5634);
    bus_wr(4'd0, 2'b11, 16'hFFFF);
    bus_wr(4'd9, 2'b11, 16'hFFFF);
    bus_rd(4'd9);
    check("R5 unused index", bus_rdata_o, 16'h0000);

    // R3 lock control
    bus_wr(4'd8, 2'b11, 16'h0001);
    bus_rd(4'd8);
    check("R3 writing 1 keeps lock", bus_rdata_o, 16'h0001);
    bus_wr(4'd8, 2'b01, 16'h0000);
    check("R3 pad_oe after unlock", pad_oe_o, 16'hF00F);
    check("R3 pad_out after unlock", pad_out_o, 16'h5634);
    check("R11 pull_en inputs only", pad_pull_en_o, 16'h0FF0);
    check("R11 pull_up", pad_pull_up_o, 16'h00F0);
    bus_wr(4'd8, 2'b01, 16'h0001);
    bus_rd(4'd8);
    check("R3 lock stays clear", bus_rdata_o, 16'h0000);

    // R7 rising edges, R6 input read
    @(negedge clk_i); pad_in_i = 16'h0003;
    idle(2);
    bus_rd(4'd0);
    check("R6 input sampled", bus_rdata_o, 16'h0003);
    idle(2);
    bus_rd(4'd7);
    check("R7 rising flags", bus_rdata_o, 16'h0003);
    check("R9 irq without enable", {15'd0, irq_o}, 16'h0);
    bus_wr(4'd5, 2'b01, 16'h0001);
    check("R9 irq with enable", {15'd0, irq_o}, 16'h0001);

    // R8 clear, R10 edge select change
    bus_wr(4'd7, 2'b11, 16'h0000);
    check("R8 clear flags irq", {15'd0, irq_o}, 16'h0);
    bus_wr(4'd6, 2'b01, 16'h0001);
    bus_wr(4'd6, 2'b01, 16'h0000);
    bus_wr(4'd6, 2'b01, 16'h0001);
    idle(3);
    bus_rd(4'd7);
    check("R10 no flag from edge select", bus_rdata_o, 16'h0000);

    // R7 falling selection
    @(negedge clk_i); pad_in_i = 16'h0000;
    idle(4);
    bus_rd(4'd7);
    check("R7 falling only where selected", bus_rdata_o, 16'h0001);
    bus_wr(4'd7, 2'b11, 16'hFFFF);
    bus_rd(4'd7);
    check("R8 write 1 keeps", bus_rdata_o, 16'h0001);

    // R8 set wins over clear in the same cycle
    bus_wr(4'd7, 2'b11, 16'h0000);
    @(negedge clk_i); pad_in_i = 16'h0001;
    idle(4);
    @(negedge clk_i); pad_in_i = 16'h0000;
    idle(1);
    bus_wr(4'd7, 2'b11, 16'h0000);
    bus_rd(4'd7);
    check("R8 set wins over clear", bus_rdata_o, 16'h0001);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if ($urandom % 4 == 0) pad_in_i = 16'($urandom);
      bus_sel_i   = 1'($urandom);
      bus_we_i    = 1'($urandom);
      bus_addr_i  = 4'($urandom % 10);
      bus_be_i    = 2'($urandom);
      bus_wdata_i = 16'($urandom);
    end
    @(negedge clk_i);
    bus_sel_i = 0;
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule